// File: doc/BRIEF.md
# Host Bridge Device Configuration Registers

This block holds the device-specific part of a host bridge's 256-byte configuration space, offsets 0x40 to 0xFF. A 32-bit word port with four byte-lane enables reaches it. Every byte has one of three fixed behaviours: read-only, read/write, or write-one-to-clear status. On reset each byte takes a fixed value.

The block sends the memory bank boundary bytes, the bank-enable byte and the first memory configuration word straight to a memory decoder. A one-cycle update strobe tells the decoder to re-evaluate its windows after any write that lands on those registers. Thirty-two error-event inputs set the status bits. The standard header below 0x40 is served elsewhere. Here it reads as zero, and writes to it are dropped.

The access port is a plain register port, with no valid/ready handshake. A write takes effect at the clock edge where `acc_wr` is high. `acc_rdata` follows `acc_addr` combinationally, and a read never changes any state, so there is no back-pressure to manage.

Top module: `hb_cfg_regs`

## Requirements
- R1: After reset the words read as follows: 0xA8 reads 0xFF000010, 0xAC reads 0x000C060C, 0xB8 reads 0x00040000, 0xC0 reads 0x00000001, 0xF0 reads 0xFF020000, 0xF4 reads 0x00000003 and 0xFC reads 0x00100000. Every other byte from 0x40 up reads 0. The byte at offset 4w+l sits in lane l (bits 8l+7..8l) of word address w = offset/4.
- R2: Writable bytes take the lane data of a write only when their lane enable is set. The writable bytes are 0x70-0x71, 0x80-0xA0, 0xA8-0xAF, 0xBA-0xBB, 0xC0 and 0xC4.
- R3: A write leaves every read-only byte in 0x40-0xEF unchanged, so it keeps reading 0.
- R4: A high `err_evt` bit sets a status bit at the next edge. Bit 8k+b sets bit b of status byte 0xC1+2k, for k = 0..3.
- R5: Writing 1 to a status bit clears it. Writing 0 to it has no effect.
- R6: When an error event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: `map_upd` is high for exactly the cycle after a write that enables any byte in 0x80-0xA0 or 0xF0-0xF3. It stays low after every other write, including one with no lane enabled.
- R8: The outputs `bound_lo`, `bound_lo_ext`, `bound_hi` and `bound_hi_ext` carry bytes 0x80-0x87, 0x88-0x8F, 0x90-0x97 and 0x98-0x9F, bank i in bits 8i+7..8i. `bank_en` is byte 0xA0, and `mcfg1` is word 0xF0, whose bit 19 is the memory-go enable.
- R9: Word addresses below 0x10 (offsets 0x00-0x3F) read 0 and ignore writes. A read changes nothing.
- R10: Bytes 0xF0-0xFF are fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_wr | input | 1 | Write request this cycle |
| acc_addr | input | 6 | Word address (offset bits 7..2) |
| acc_be | input | 4 | Byte-lane enables for writes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr` |
| err_evt | input | 32 | Error events that set status bits |
| bound_lo | output | 64 | Bank start bytes |
| bound_lo_ext | output | 64 | Bank start extension bytes |
| bound_hi | output | 64 | Bank end bytes |
| bound_hi_ext | output | 64 | Bank end extension bytes |
| bank_en | output | 8 | Bank enable byte |
| mcfg1 | output | 32 | Memory configuration word 1 |
| map_upd | output | 1 | Mapping-update strobe |

## Verification
The bench writes all-ones into words that mix writable, read-only and status lanes, such as 0x70, 0xB8, 0xC0 and 0xA0. A wrong attribute table shows up there as a stray 1 or a lost byte.

For the strobe, the bench compares a write to 0xA0 and a byte write to 0xF2 against writes to 0xA8 and 0xFC. It also writes to 0x80 with no lane enabled. A design that decodes only the word's first byte, or ignores lane enables, either misses a pulse or pulses falsely.

Status bits are tested with a set-and-clear in the same cycle, a write of zero, and events on every slot. A design with clear-over-set priority loses an event. A wrong slot mapping lights the wrong byte.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;
  localparam int CFG_BYTES = 256;
  localparam int DEV_BASE  = 64;
  localparam int LANES     = 4;
  localparam int NB        = CFG_BYTES - DEV_BASE;
  localparam int AW        = $clog2(CFG_BYTES / LANES);
  localparam int DW        = 8 * LANES;
  localparam int W1C_N     = 4;
  localparam int ERR_W     = 8 * W1C_N;
  localparam int BANKS     = 8;
  localparam int FIRST_W   = DEV_BASE / LANES;
  localparam int NW        = NB / LANES;
  // memory mapping window and config word offsets
  localparam int MAP_LO    = 'h80;
  localparam int MAP_HI    = 'hA0;
  localparam int MCFG1_OFF = 'hF0;
  localparam int W1C_FIRST = 'hC1;

  typedef enum logic [1:0] {K_RO, K_RW, K_W1C} kind_e;

  function automatic kind_e byte_kind(int off);
    if (off == 'hC1 || off == 'hC3 || off == 'hC5 || off == 'hC7) return K_W1C;
    if (off == 'h70 || off == 'h71) return K_RW;
    if (off >= MAP_LO && off <= MAP_HI) return K_RW;
    if (off >= 'hA8 && off <= 'hAF) return K_RW;
    if (off == 'hBA || off == 'hBB) return K_RW;
    if (off == 'hC0 || off == 'hC4) return K_RW;
    if (off >= MCFG1_OFF) return K_RW;
    return K_RO;
  endfunction

  function automatic logic [7:0] byte_rst(int off);
    case (off)
      'hA8: return 8'h10;
      'hAB: return 8'hFF;
      'hAC: return 8'h0C;
      'hAD: return 8'h06;
      'hAE: return 8'h0C;
      'hBA: return 8'h04;
      'hC0: return 8'h01;
      'hF2: return 8'h02;
      'hF3: return 8'hFF;
      'hF4: return 8'h03;
      'hFE: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int w1c_slot(int off);
    return (off - W1C_FIRST) / 2;
  endfunction
endpackage

// File: rtl/hbcfg_rw_byte.sv
module hbcfg_rw_byte #(
  parameter logic [7:0] RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wd,
  output logic [7:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST;
    else if (we) q <= wd;
  end
endmodule

// File: rtl/hbcfg_w1c_byte.sv
module hbcfg_w1c_byte (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wd,
  input  logic [7:0] set_ev,
  output logic [7:0] q
);
  logic [7:0] clr;
  assign clr = we ? wd : 8'h00;

  // an event in the same cycle wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst) q <= 8'h00;
    else q <= set_ev | (q & ~clr);
  end
endmodule

// File: rtl/hbcfg_strobe.sv
module hbcfg_strobe import hbcfg_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] be,
  output logic             map_upd
);
  logic [LANES-1:0] lane_hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] off;
    assign off = {addr, 2'(l)};
    assign lane_hit[l] = be[l] &&
      ((off >= 8'(MAP_LO) && off <= 8'(MAP_HI)) ||
       (off >= 8'(MCFG1_OFF) && off <= 8'(MCFG1_OFF + LANES - 1)));
  end

  always_ff @(posedge clk) begin
    if (rst) map_upd <= 1'b0;
    else map_upd <= wr && (|lane_hit);
  end
endmodule

// File: rtl/hb_cfg_regs.sv
module hb_cfg_regs import hbcfg_pkg::*; (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_wr,
  input  logic [AW-1:0]        acc_addr,
  input  logic [LANES-1:0]     acc_be,
  input  logic [DW-1:0]        acc_wdata,
  output logic [DW-1:0]        acc_rdata,
  input  logic [ERR_W-1:0]     err_evt,
  output logic [8*BANKS-1:0]   bound_lo,
  output logic [8*BANKS-1:0]   bound_lo_ext,
  output logic [8*BANKS-1:0]   bound_hi,
  output logic [8*BANKS-1:0]   bound_hi_ext,
  output logic [BANKS-1:0]     bank_en,
  output logic [DW-1:0]        mcfg1,
  output logic                 map_upd
);
  logic [7:0] cfg_b [NB];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam int    OFF = DEV_BASE + i;
    localparam kind_e K   = byte_kind(OFF);
    localparam int    L   = OFF % LANES;
    if (K == K_RW) begin : g_rw
      logic we;
      assign we = acc_wr && acc_be[L] && (acc_addr == AW'(OFF / LANES));
      hbcfg_rw_byte #(.RST(byte_rst(OFF))) u_b (
        .clk(clk), .rst(rst), .we(we),
        .wd(acc_wdata[8*L +: 8]), .q(cfg_b[i])
      );
    end else if (K == K_W1C) begin : g_w1c
      localparam int S = w1c_slot(OFF);
      logic we;
      assign we = acc_wr && acc_be[L] && (acc_addr == AW'(OFF / LANES));
      hbcfg_w1c_byte u_b (
        .clk(clk), .rst(rst), .we(we), .wd(acc_wdata[8*L +: 8]),
        .set_ev(err_evt[8*S +: 8]), .q(cfg_b[i])
      );
    end else begin : g_ro
      assign cfg_b[i] = byte_rst(OFF);
    end
  end

  // read mux: header words read as zero
  always_comb begin
    acc_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (acc_addr == AW'(FIRST_W + w)) begin
        for (int l = 0; l < LANES; l++) acc_rdata[8*l +: 8] = cfg_b[w*LANES + l];
      end
    end
  end

  for (genvar j = 0; j < BANKS; j++) begin : g_bank
    assign bound_lo[8*j +: 8]     = cfg_b[MAP_LO - DEV_BASE + j];
    assign bound_lo_ext[8*j +: 8] = cfg_b[MAP_LO - DEV_BASE + BANKS + j];
    assign bound_hi[8*j +: 8]     = cfg_b[MAP_LO - DEV_BASE + 2*BANKS + j];
    assign bound_hi_ext[8*j +: 8] = cfg_b[MAP_LO - DEV_BASE + 3*BANKS + j];
  end
  assign bank_en = cfg_b[MAP_HI - DEV_BASE];

  for (genvar l = 0; l < LANES; l++) begin : g_mcfg
    assign mcfg1[8*l +: 8] = cfg_b[MCFG1_OFF - DEV_BASE + l];
  end

  hbcfg_strobe u_strobe (
    .clk(clk), .rst(rst), .wr(acc_wr), .addr(acc_addr),
    .be(acc_be), .map_upd(map_upd)
  );
endmodule

// File: rtl/hb_cfg_regs_chk.sv
module hb_cfg_regs_chk import hbcfg_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic             acc_wr,
  input logic [AW-1:0]    acc_addr,
  input logic [LANES-1:0] acc_be,
  input logic [DW-1:0]    acc_wdata,
  input logic [ERR_W-1:0] err_evt,
  input logic [BANKS-1:0] bank_en,
  input logic [DW-1:0]    mcfg1,
  input logic             map_upd,
  input logic [7:0]       cfg_b [NB]
);
  localparam int ST0 = W1C_FIRST - DEV_BASE;

  // R7
  upd_bank_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_wr && acc_be[0] && acc_addr == 6'h28)) |-> map_upd);

  // R7
  upd_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    map_upd |-> $past(acc_wr));

  // R4
  w1c_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_evt[0])) |-> cfg_b[ST0][0]);

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_wr && acc_addr == 6'h30 && acc_be[1] &&
                          acc_wdata[8] && !err_evt[0])) |-> !cfg_b[ST0][0]);

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_wr)) |-> $stable(bank_en));

  // R10
  mcfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_wr)) |-> $stable(mcfg1));
endmodule

bind hb_cfg_regs hb_cfg_regs_chk u_chk (.*);

// File: tb/hb_cfg_regs_test.sv
module hb_cfg_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr = 1'b0;
  logic [5:0]  acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [31:0] err_evt = '0;
  logic [63:0] bound_lo, bound_lo_ext, bound_hi, bound_hi_ext;
  logic [7:0]  bank_en;
  logic [31:0] mcfg1;
  logic        map_upd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_cfg_regs uut (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .err_evt(err_evt), .bound_lo(bound_lo), .bound_lo_ext(bound_lo_ext),
    .bound_hi(bound_hi), .bound_hi_ext(bound_hi_ext), .bank_en(bank_en),
    .mcfg1(mcfg1), .map_upd(map_upd)
  );

  // {expected strobe, word address, lane enables, write data, expected read}
  localparam int NV = 13;
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 6'h20, 4'hF, 32'h11223344, 32'h11223344},  // R2 full word
    {1'b1, 6'h20, 4'h5, 32'hAABBCCDD, 32'h11BB33DD},  // R2 lanes 0,2
    {1'b0, 6'h10, 4'hF, 32'hFFFFFFFF, 32'h00000000},  // R3 0x40
    {1'b0, 6'h1C, 4'hF, 32'hFFFFFFFF, 32'h0000FFFF},  // R2 R3 0x70
    {1'b0, 6'h2E, 4'hF, 32'hFFFFFFFF, 32'hFFFF0000},  // R2 R3 0xB8
    {1'b0, 6'h30, 4'hF, 32'hFFFFFF5A, 32'h0000005A},  // R2 R5 0xC0
    {1'b0, 6'h31, 4'hF, 32'h000000A5, 32'h000000A5},  // R2 0xC4
    {1'b1, 6'h3C, 4'hF, 32'h00080000, 32'h00080000},  // R10 0xF0
    {1'b0, 6'h3F, 4'hF, 32'h12345678, 32'h12345678},  // R10 0xFC
    {1'b0, 6'h2B, 4'h8, 32'h77000000, 32'h770C060C},  // R2 0xAC lane3
    {1'b0, 6'h0F, 4'hF, 32'hFFFFFFFF, 32'h00000000},  // R9 header
    {1'b1, 6'h28, 4'hF, 32'hFFFFFFFF, 32'h000000FF},  // R2 R3 0xA0
    {1'b0, 6'h20, 4'h0, 32'hFFFFFFFF, 32'h11BB33DD}   // R7 no lanes
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    acc_addr = a;
    #1;
    d = acc_rdata;
  endtask

  task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d, logic [31:0] ev);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_be = be; acc_wdata = d; err_evt = ev;
    @(negedge clk);
    acc_wr = 1'b0; acc_be = '0; err_evt = '0;
  endtask

  task automatic pulse_err(logic [31:0] ev);
    @(negedge clk);
    err_evt = ev;
    @(negedge clk);
    err_evt = '0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    rd(6'h2A, d); check("R1 0xA8", d, 32'hFF000010);
    rd(6'h2B, d); check("R1 0xAC", d, 32'h000C060C);
    rd(6'h2E, d); check("R1 0xB8", d, 32'h00040000);
    rd(6'h30, d); check("R1 0xC0", d, 32'h00000001);
    rd(6'h3C, d); check("R1 0xF0", d, 32'hFF020000);
    rd(6'h3D, d); check("R1 0xF4", d, 32'h00000003);
    rd(6'h3F, d); check("R1 0xFC", d, 32'h00100000);
    rd(6'h20, d); check("R1 0x80", d, 32'h00000000);
    check("R1 mcfg1 port", mcfg1, 32'hFF020000);
    check("R1 strobe idle", {31'b0, map_upd}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][73:68], VEC[i][67:64], VEC[i][63:32], 32'h0);
      check("R7 strobe", {31'b0, map_upd}, {31'b0, VEC[i][74]});
      rd(VEC[i][73:68], d);
      check("R2 R3 R9 R10 table", d, VEC[i][31:0]);
      @(negedge clk);
      check("R7 one cycle", {31'b0, map_upd}, 32'h0);
    end

    // R8 exported fields
    check("R8 bound_lo", bound_lo[31:0], 32'h11BB33DD);
    check("R8 bank_en", {24'b0, bank_en}, 32'h000000FF);
    check("R8 mcfg1 go bit", {31'b0, mcfg1[19]}, 32'h1);
    wr(6'h24, 4'hF, 32'hCAFE0102, 32'h0);
    check("R8 bound_hi", bound_hi[31:0], 32'hCAFE0102);
    check("R7 0x90 strobe", {31'b0, map_upd}, 32'h1);

    // R7 byte write into the memory-go byte only
    wr(6'h3C, 4'h4, 32'h00000000, 32'h0);
    check("R7 0xF2 strobe", {31'b0, map_upd}, 32'h1);
    check("R8 go cleared", {31'b0, mcfg1[19]}, 32'h0);

    // R4 set via event, R9 read has no side effect
    pulse_err(32'h00000001);
    rd(6'h30, d); check("R4 C1 bit0", d, 32'h0000015A);
    rd(6'h30, d2); check("R9 reread", d2, d);
    wr(6'h30, 4'h2, 32'h00000000, 32'h0);
    rd(6'h30, d); check("R5 zero no effect", d, 32'h0000015A);
    wr(6'h30, 4'h2, 32'h00000100, 32'h00000001);
    rd(6'h30, d); check("R6 set wins", d, 32'h0000015A);
    wr(6'h30, 4'h2, 32'h00000100, 32'h0);
    rd(6'h30, d); check("R5 clear", d, 32'h0000005A);

    // R4 slot mapping
    pulse_err(32'h80010100);
    rd(6'h30, d); check("R4 C3 bit0", d, 32'h0100005A);
    rd(6'h31, d); check("R4 C5 C7", d, 32'h800001A5);
    wr(6'h31, 4'hA, 32'h80000100, 32'h0);
    rd(6'h31, d); check("R5 C5 C7 clear", d, 32'h000000A5);
    check("R7 status no strobe", {31'b0, map_upd}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule